// File: doc/BRIEF.md
# Serial CSD Multiplier for Partitioned SIMD Words

This block scales every sub-word of a 48-bit packed word by one shared scalar. The scalar and the sub-words are fixed-point numbers with a single integer bit, so each value lies in [-1, 1). At a start pulse the block captures the packed word, the lane format and the scalar. It rewrites the scalar as a string of signed digits (+1, 0, -1) in which no two neighbouring digits are both nonzero. It then walks those digits from the least significant end, one step per clock. Each step adds, subtracts or skips the captured word and then shifts the running sum right by one to three places at once, so a run of zero digits costs fewer clocks.

All lanes share one adder and one shifter. Carries and borrows are cut at lane edges, and sign bits are replicated inside each lane, so lanes never disturb each other. Each product has the same width as its lane and keeps the lane's fixed-point scaling. Bits shifted out below the lane are dropped. A one-cycle completion pulse marks the clock in which the product word is valid. The word then holds until the next accepted start.

Top module: `csd_simd_mul`

## Requirements
- R1: `fmt_sel` picks the lane width: 0 gives 4 bits, 1 gives 6, 2 gives 8, 3 gives 12, 4 gives 16, and 5 to 7 also give 16. Lane j occupies bits [j*W +: W] of `mcand` and `product`.
- R2: The scalar is the low `mplier_w` bits of `mplier`, read as two's complement and scaled by 2^-(w-1). It is recoded into a non-adjacent signed-digit string of the same value. For a 16-bit scalar 16'h7FFF this gives only two nonzero digits, and the run takes 6 cycles.
- R3: Each lane starts from zero. Digits are handled from the least significant. One step computes acc ± x (or keeps acc) wrapped to W bits, then shifts it right arithmetically by the step's shift amount. The step for the top digit does not shift.
- R4: A step taken at digit position k shifts by s = min(3, w-1-k, 1 + number of zero digits directly above k). The next step is taken at k+s. The run length L is the number of steps, and `done` rises L cycles after the clock edge that accepted `start`. A 16-bit scalar 16'h0001 takes 6 cycles.
- R5: Each product keeps W bits, and low bits shifted out are truncated. A scalar equal to zero gives an all-zero `product` for any `mcand`.
- R6: After reset, `product` is zero and `done` is low. `done` is high for exactly one cycle per run. `product` holds its value while the block is idle and no start is accepted.
- R7: `start` and all operand inputs are ignored while a run is in progress. The run in progress finishes with its own operands and timing, and the ignored start is not queued.
- R8: No carry, borrow or sign bit crosses a lane boundary, including in lanes that wrap on overflow.
- R9: A `mplier_w` below 2 acts as 2, and a value above 16 acts as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when the block is idle |
| mcand | input | 48 | Packed multiplicand sub-words |
| mplier | input | 16 | Scalar multiplier, two's complement in its low bits |
| mplier_w | input | 5 | Number of valid scalar bits |
| fmt_sel | input | 3 | Lane width select |
| product | output | 48 | Packed product sub-words |
| done | output | 1 | One-cycle pulse, product valid |

## Verification
A wrong recoded digit or a wrong add/subtract choice shows only as a wrong lane value at the `done` pulse, at most 16 cycles after start. A wrong shift amount or a wrong lookahead moves the `done` pulse to an earlier or later cycle, so the bench measures the start-to-done distance for every run. A wrong lane-boundary mask corrupts a neighbouring lane, which shows when lanes at the extreme values sit side by side. Accepting a start in the middle of a run shows as a changed product or a shifted or extra `done` pulse.

// File: rtl/csd_simd_mul.sv
module csd_simd_mul #(
  parameter int DATA_W    = 48,
  parameter int MULT_W    = 16,
  parameter int MW_SEL_W  = 5,
  parameter int FMT_SEL_W = 3,
  parameter int NUM_FMT   = 5,
  parameter int LANE_W [NUM_FMT] = '{4, 6, 8, 12, 16},
  parameter int MAX_SHIFT = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [DATA_W-1:0]    mcand,
  input  logic [MULT_W-1:0]    mplier,
  input  logic [MW_SEL_W-1:0]  mplier_w,
  input  logic [FMT_SEL_W-1:0] fmt_sel,
  output logic [DATA_W-1:0]    product,
  output logic                 done
);

  localparam int DIG_W = MULT_W + 2;
  localparam int IDX_W = $clog2(MULT_W);
  localparam int S_W   = $clog2(MAX_SHIFT + 1);

  logic              busy_q, done_q;
  logic [DATA_W-1:0] acc_q, x_q, lsb_q, msb_q;
  logic [MULT_W-1:0] pos_q, neg_q;
  logic [IDX_W-1:0]  k_q, last_q;

  logic [DATA_W-1:0] lsb_tab [NUM_FMT];
  logic [DATA_W-1:0] msb_tab [NUM_FMT];

  for (genvar f = 0; f < NUM_FMT; f++) begin : g_fmt
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign lsb_tab[f][b] = (b % LANE_W[f]) == 0;
      assign msb_tab[f][b] = ((b % LANE_W[f]) == LANE_W[f] - 1) || (b == DATA_W - 1);
    end
  end

  wire accept = start && !busy_q;

  // scalar capture and signed-digit recoding
  logic [DIG_W-1:0]  mv, tri3, flip;
  logic [MULT_W-1:0] pos_n, neg_n;
  logic [IDX_W-1:0]  last_n;
  int                fidx;

  always_comb begin
    int w;
    w = int'(mplier_w);
    if (w < 2) w = 2;
    if (w > MULT_W) w = MULT_W;
    last_n = IDX_W'(w - 1);
    for (int i = 0; i < DIG_W; i++) begin
      int j;
      j = (i < w) ? i : w - 1;
      mv[i] = mplier[j[IDX_W-1:0]];
    end
    tri3  = mv + (mv << 1);
    flip  = tri3 ^ mv;
    pos_n = MULT_W'((tri3 & flip) >> 1);
    neg_n = MULT_W'((mv & flip) >> 1);
    fidx  = (int'(fmt_sel) >= NUM_FMT) ? NUM_FMT - 1 : int'(fmt_sel);
  end

  // shift amount from zero-run lookahead
  wire [MULT_W+MAX_SHIFT-1:0] nz_ext = {{MAX_SHIFT{1'b0}}, pos_q | neg_q};
  logic [S_W-1:0] sh_amt;

  always_comb begin
    int   kk, rem;
    logic stop;
    kk     = int'(k_q);
    rem    = int'(last_q) - kk;
    stop   = 1'b0;
    sh_amt = '0;
    if (rem > 0) begin
      sh_amt = S_W'(1);
      for (int t = 1; t < MAX_SHIFT; t++) begin
        if (!stop && rem > t && !nz_ext[kk + t]) sh_amt = S_W'(t + 1);
        else stop = 1'b1;
      end
    end
  end

  // lane-partitioned add/subtract and arithmetic shift
  wire do_add = pos_q[k_q];
  wire do_sub = neg_q[k_q];
  wire [DATA_W-1:0] addend = do_sub ? ~x_q : (do_add ? x_q : '0);

  function automatic logic [DATA_W-1:0] asr1(input logic [DATA_W-1:0] v,
                                             input logic [DATA_W-1:0] m);
    asr1[DATA_W-1] = v[DATA_W-1];
    for (int b = 0; b < DATA_W - 1; b++) asr1[b] = m[b] ? v[b] : v[b+1];
  endfunction

  logic [DATA_W-1:0] sum, shifted;

  always_comb begin
    logic c;
    c = do_sub;
    for (int i = 0; i < DATA_W; i++) begin
      if (lsb_q[i]) c = do_sub;
      sum[i] = acc_q[i] ^ addend[i] ^ c;
      c = (acc_q[i] & addend[i]) | (c & (acc_q[i] ^ addend[i]));
    end
    shifted = sum;
    for (int g = 1; g <= MAX_SHIFT; g++)
      if (g <= int'(sh_amt)) shifted = asr1(shifted, msb_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      acc_q  <= '0;
      x_q    <= '0;
      lsb_q  <= '0;
      msb_q  <= '0;
      pos_q  <= '0;
      neg_q  <= '0;
      k_q    <= '0;
      last_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        acc_q  <= '0;
        x_q    <= mcand;
        lsb_q  <= lsb_tab[fidx];
        msb_q  <= msb_tab[fidx];
        pos_q  <= pos_n;
        neg_q  <= neg_n;
        k_q    <= '0;
        last_q <= last_n;
      end else if (busy_q) begin
        acc_q <= shifted;
        k_q   <= k_q + IDX_W'(sh_amt);
        if (sh_amt == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign product = acc_q;
  assign done    = done_q;

endmodule

// File: rtl/csd_simd_mul_chk.sv
module csd_simd_mul_chk #(
  parameter int DATA_W    = 48,
  parameter int MULT_W    = 16,
  parameter int IDX_W     = 4,
  parameter int S_W       = 2,
  parameter int MAX_SHIFT = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [IDX_W-1:0]  k,
  input logic [IDX_W-1:0]  last,
  input logic [S_W-1:0]    shamt,
  input logic [MULT_W-1:0] pos,
  input logic [MULT_W-1:0] neg,
  input logic [DATA_W-1:0] product
);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));

  a_r4_shift_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(shamt) <= MAX_SHIFT) && (int'(k) + int'(shamt) <= int'(last)));

  a_r4_last_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && shamt == '0) |=> done);

  a_r2_nonadjacent: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (((pos | neg) & ((pos | neg) >> 1)) == '0) && ((pos & neg) == '0));

  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && shamt != '0) |=> busy && (int'(k) == int'($past(k)) + int'($past(shamt))));

  a_r5_zero_mult: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pos == '0 && neg == '0) |-> product == '0);

endmodule

bind csd_simd_mul csd_simd_mul_chk #(
  .DATA_W(DATA_W), .MULT_W(MULT_W), .IDX_W(IDX_W), .S_W(S_W), .MAX_SHIFT(MAX_SHIFT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_q), .done(done_q),
  .k(k_q), .last(last_q), .shamt(sh_amt), .pos(pos_q), .neg(neg_q), .product(acc_q)
);

// File: tb/csd_simd_mul_tb.sv
module csd_simd_mul_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [47:0] mcand = '0;
  logic [15:0] mplier = '0;
  logic [4:0]  mplier_w = 5'd8;
  logic [2:0]  fmt_sel = '0;
  logic [47:0] product;
  logic        done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  csd_simd_mul dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
    .mplier_w(mplier_w), .fmt_sel(fmt_sel), .product(product), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int lane_w(input int f);
    case (f)
      0: return 4;
      1: return 6;
      2: return 8;
      3: return 12;
      default: return 16;
    endcase
  endfunction

  function automatic longint sxt(input longint v, input int w);
    longint t;
    t = v & ((longint'(1) << w) - 1);
    if (((t >> (w - 1)) & 1) != 0) t = t - (longint'(1) << w);
    return t;
  endfunction

  function automatic void ref_mul(input logic [47:0] x, input int f, input logic [15:0] m,
                                  input int mwi, output logic [47:0] p, output int cyc);
    int     w, mw, nl, k, s, rem;
    bit     fin;
    longint v, r, xl;
    int     dg [24];
    longint acc [12];
    w  = lane_w(f);
    mw = (mwi < 2) ? 2 : ((mwi > 16) ? 16 : mwi);
    nl = 48 / w;
    v  = sxt(longint'(m), mw);
    for (int i = 0; i < 24; i++) begin
      if ((v & 1) != 0) begin
        r = v & 3;
        dg[i] = (r == 1) ? 1 : -1;
        v = v - dg[i];
      end else dg[i] = 0;
      v = v / 2;
    end
    for (int j = 0; j < 12; j++) acc[j] = 0;
    k = 0; cyc = 0; fin = 0;
    for (int g = 0; g < 40; g++) begin
      if (!fin) begin
        cyc++;
        rem = mw - 1 - k;
        s = 0;
        if (rem > 0) begin
          s = 1;
          while (s < 3 && rem > s && dg[k + s] == 0) s++;
        end
        for (int j = 0; j < nl; j++) begin
          xl = sxt(longint'(x >> (j * w)), w);
          acc[j] = sxt(acc[j] + dg[k] * xl, w);
          acc[j] = acc[j] >>> s;
        end
        if (s == 0) fin = 1;
        else k += s;
      end
    end
    p = '0;
    for (int j = 0; j < nl; j++)
      p = p | (48'(acc[j] & ((longint'(1) << w) - 1)) << (j * w));
  endfunction

  task automatic run_op(input logic [47:0] x, input int f, input logic [15:0] m, input int mwi,
                        input bit inject, input string req,
                        output logic [47:0] got, output int cyc);
    logic [47:0] exp_p;
    int          exp_c;
    logic [47:0] held;
    ref_mul(x, f, m, mwi, exp_p, exp_c);
    @(negedge clk);
    mcand = x; fmt_sel = 3'(f); mplier = m; mplier_w = 5'(mwi); start = 1'b1;
    @(negedge clk);
    if (inject) begin
      mcand = ~x; mplier = ~m; fmt_sel = 3'd0; mplier_w = 5'd16; start = 1'b1;
    end else start = 1'b0;
    cyc = 0;
    got = '0;
    while (cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) start = 1'b0;
      if (done) begin
        got = product;
        break;
      end
    end
    chk(got == exp_p, req, "product", 64'(got), 64'(exp_p));
    chk(cyc == exp_c, "R4", "start-to-done cycles", 64'(cyc), 64'(exp_c));
    held = product;
    @(negedge clk);
    chk(done == 1'b0, "R6", "done width", 64'(done), 64'd0);
    repeat (3) @(negedge clk);
    chk(product == held && done == 1'b0, "R6", "idle hold", 64'(product), 64'(held));
  endtask

  task automatic t_reset();
    chk(product == '0, "R6", "reset product", 64'(product), 64'd0);
    chk(done == 1'b0, "R6", "reset done", 64'(done), 64'd0);
  endtask

  task automatic t_basic();
    logic [47:0] p; int c;
    run_op(48'h7F80_40C0_01FF, 2, 16'h0060, 8, 0, "R3", p, c);
    run_op(48'h1122_3344_5566, 2, 16'h00A5, 8, 0, "R3", p, c);
    run_op(48'hF00D_CAFE_0B0E, 2, 16'h0081, 8, 0, "R5", p, c);
  endtask

  task automatic t_formats();
    logic [47:0] p, q; int c;
    for (int f = 0; f < 5; f++)
      run_op(48'h8765_4321_ABCD, f, 16'h2D3B, 14, 0, "R1", p, c);
    run_op(48'h8765_4321_ABCD, 4, 16'h2D3B, 14, 0, "R1", p, c);
    run_op(48'h8765_4321_ABCD, 7, 16'h2D3B, 14, 0, "R1", q, c);
    chk(p == q, "R1", "select 7 acts as 16-bit lanes", 64'(q), 64'(p));
  endtask

  task automatic t_zero();
    logic [47:0] p; int c;
    run_op(48'hFFFF_8000_7FFF, 3, 16'h0000, 12, 0, "R5", p, c);
    chk(p == '0, "R5", "zero scalar", 64'(p), 64'd0);
  endtask

  task automatic t_runs();
    logic [47:0] p; int c;
    run_op(48'h7FFF_8000_4001, 4, 16'h0001, 16, 0, "R4", p, c);
    chk(c == 6, "R4", "split zero run cycles", 64'(c), 64'd6);
    run_op(48'h7FFF_8000_4001, 4, 16'h7FFF, 16, 0, "R2", p, c);
    chk(c == 6, "R2", "recoded all-ones cycles", 64'(c), 64'd6);
    run_op(48'h1234_5678_9ABC, 4, 16'h4000, 16, 0, "R4", p, c);
    run_op(48'h1234_5678_9ABC, 1, 16'h5555, 16, 0, "R2", p, c);
  endtask

  task automatic t_isolation();
    logic [47:0] p; int c;
    run_op(48'h8787_8787_8787, 0, 16'h0008, 4, 0, "R8", p, c);
    chk(p == 48'h8989_8989_8989, "R8", "wrapped lanes", 64'(p), 64'h8989_8989_8989);
    run_op(48'hFFFF_FFFF_FFFF, 1, 16'h0003, 3, 0, "R8", p, c);
    run_op(48'h0001_0001_0001, 0, 16'h00FF, 8, 0, "R8", p, c);
  endtask

  task automatic t_clamp();
    logic [47:0] p, q; int c;
    run_op(48'h6A5C_3E91_B724, 2, 16'hFFFE, 2, 0, "R9", p, c);
    run_op(48'h6A5C_3E91_B724, 2, 16'hFFFE, 0, 0, "R9", q, c);
    chk(p == q, "R9", "width 0 as 2", 64'(q), 64'(p));
    run_op(48'h6A5C_3E91_B724, 4, 16'hB3C7, 16, 0, "R9", p, c);
    run_op(48'h6A5C_3E91_B724, 4, 16'hB3C7, 31, 0, "R9", q, c);
    chk(p == q, "R9", "width 31 as 16", 64'(q), 64'(p));
  endtask

  task automatic t_busy_start();
    logic [47:0] p; int c;
    run_op(48'h2468_ACE0_1357, 3, 16'h9249, 16, 1, "R7", p, c);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog: actual no finish expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_formats();
    t_zero();
    t_runs();
    t_isolation();
    t_clamp();
    t_busy_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule